// File: doc/BRIEF.md
# ALU with Condition Flags

This block is the combinational data-processing unit of a 32-bit load/store core. It takes an opcode, a first operand, and a second operand that has already been shifted. It also takes the carry that the shifter produced, the current C and V flags, and a set-flags bit. From these it computes a result, a result-write enable, the next values of the N, Z, C and V flags, and one enable that tells the flag register whether to load them.

Arithmetic opcodes cover plain add, subtract, and add-with-carry. Add-with-carry lets a wide sum be built one word at a time: the low words go through add with flags set, then the high words go through add-with-carry. The logical opcodes are AND, OR, XOR, bit-clear, pass-through, and inverted pass-through. Three test opcodes compute a value only to set flags and never write it back: AND-test, XOR-test and compare. The shifter, the flag register, multiplication and division lie outside this block.

Top module: `alu_flags`

## Requirements
- R1: Opcode encoding: 0 AND, 1 EOR, 2 SUB, 3 ADD, 4 ADC, 5 TST, 6 TEQ, 7 CMP, 8 ORR, 9 MOV, 10 BIC, 11 MVN. `resWe` is 1 for opcodes 0-4 and 8-11, and 0 for TST, TEQ and CMP.
- R2: ADD gives A+B, ADC gives A+B+curC, and SUB and CMP give A-B, each modulo 2^WIDTH, on `result`.
- R3: AND gives A&B, ORR gives A|B, EOR and TEQ give A^B, TST gives A&B, BIC gives A&~B, MOV gives B, and MVN gives ~B. For example, 0x02FA62CA BIC 0x0000FFFF is 0x02FA0000.
- R4: `nNext` is the top bit of `result`. `zNext` is 1 exactly when `result` is zero. This holds for the test opcodes too, so TEQ of equal operands gives Z=1.
- R5: For ADD and ADC, `cNext` is the unsigned carry out of the top bit. For SUB and CMP, `cNext` is 1 when no borrow occurs, that is, when A >= B unsigned.
- R6: For arithmetic opcodes, `vNext` is two's-complement overflow. For logical and move opcodes, `cNext` equals `shCarry` and `vNext` equals `curV`.
- R7: `flagEn` is always 1 for TST, TEQ and CMP. For every other defined opcode, `flagEn` equals `sBit`.
- R8: A 64-bit sum of two word pairs comes out right when the low words go through ADD with sBit=1 and the high words go through ADC, with the resulting C fed back as curC.
- R9: Opcodes 12-15 are reserved. For them, `resWe` and `flagEn` are 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opCode | input | 4 | Operation select |
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Shifted second operand |
| shCarry | input | 1 | Carry out of the shifter |
| curC | input | 1 | Current C flag |
| curV | input | 1 | Current V flag |
| sBit | input | 1 | Set-flags request |
| result | output | WIDTH | Computed value |
| resWe | output | 1 | Write the result to the destination |
| flagEn | output | 1 | Load the four next-flag outputs |
| nNext | output | 1 | Next N flag |
| zNext | output | 1 | Next Z flag |
| cNext | output | 1 | Next C flag |
| vNext | output | 1 | Next V flag |

## Verification
Two decisions are made from the same inputs in the same evaluation: the result write and the flag update. A single opcode can ask for either one, both, or neither. The bench sweeps every opcode against every operand pair of a 4-bit instance, under both values of the set-flags bit, the shifter carry and the current carry. For each case it judges the result, both enables and the four flags against sums, differences and signed ranges that it computes with integer arithmetic. A 32-bit instance then takes a carry across a two-word addition and runs the bit-clear, inverted-move and equal-XOR-test cases.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

  localparam logic [3:0] OP_AND = 4'd0;
  localparam logic [3:0] OP_EOR = 4'd1;
  localparam logic [3:0] OP_SUB = 4'd2;
  localparam logic [3:0] OP_ADD = 4'd3;
  localparam logic [3:0] OP_ADC = 4'd4;
  localparam logic [3:0] OP_TST = 4'd5;
  localparam logic [3:0] OP_TEQ = 4'd6;
  localparam logic [3:0] OP_CMP = 4'd7;
  localparam logic [3:0] OP_ORR = 4'd8;
  localparam logic [3:0] OP_MOV = 4'd9;
  localparam logic [3:0] OP_BIC = 4'd10;
  localparam logic [3:0] OP_MVN = 4'd11;

  typedef enum logic [1:0] {
    LF_AND  = 2'd0,
    LF_OR   = 2'd1,
    LF_XOR  = 2'd2,
    LF_PASS = 2'd3
  } logicFn_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic     valid;     // opcode is defined
    logic     arith;     // adder path selected
    logic     subtract;  // carry-in forced to 1
    logic     addCarry;  // carry-in from current C
    logic     invertB;   // complement second operand
    logicFn_e logicFn;   // logic unit function
  } aluStrobe_t;

endpackage

// File: rtl/alu_flags_ctrl.sv
module alu_flags_ctrl
  import alu_flags_pkg::*;
(
  input  logic [3:0]  opCode,
  input  logic        sBit,
  output aluStrobe_t  strobe,
  output logic        resWe,
  output logic        flagEn
);

  logic alwaysFlags;

  always_comb begin
    strobe      = '0;
    strobe.logicFn = LF_AND;
    resWe       = 1'b0;
    alwaysFlags = 1'b0;
    case (opCode)
      OP_AND: begin strobe.valid = 1'b1; strobe.logicFn = LF_AND; resWe = 1'b1; end
      OP_EOR: begin strobe.valid = 1'b1; strobe.logicFn = LF_XOR; resWe = 1'b1; end
      OP_ORR: begin strobe.valid = 1'b1; strobe.logicFn = LF_OR;  resWe = 1'b1; end
      OP_BIC: begin
        strobe.valid = 1'b1; strobe.logicFn = LF_AND; strobe.invertB = 1'b1; resWe = 1'b1;
      end
      OP_MOV: begin strobe.valid = 1'b1; strobe.logicFn = LF_PASS; resWe = 1'b1; end
      OP_MVN: begin
        strobe.valid = 1'b1; strobe.logicFn = LF_PASS; strobe.invertB = 1'b1; resWe = 1'b1;
      end
      OP_ADD: begin strobe.valid = 1'b1; strobe.arith = 1'b1; resWe = 1'b1; end
      OP_ADC: begin
        strobe.valid = 1'b1; strobe.arith = 1'b1; strobe.addCarry = 1'b1; resWe = 1'b1;
      end
      OP_SUB: begin
        strobe.valid = 1'b1; strobe.arith = 1'b1; strobe.subtract = 1'b1;
        strobe.invertB = 1'b1; resWe = 1'b1;
      end
      OP_TST: begin strobe.valid = 1'b1; strobe.logicFn = LF_AND; alwaysFlags = 1'b1; end
      OP_TEQ: begin strobe.valid = 1'b1; strobe.logicFn = LF_XOR; alwaysFlags = 1'b1; end
      OP_CMP: begin
        strobe.valid = 1'b1; strobe.arith = 1'b1; strobe.subtract = 1'b1;
        strobe.invertB = 1'b1; alwaysFlags = 1'b1;
      end
      default: ;
    endcase
  end

  assign flagEn = alwaysFlags | (sBit & resWe);

endmodule

// File: rtl/alu_flags_dpath.sv
module alu_flags_dpath
  import alu_flags_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  aluStrobe_t        strobe,
  input  logic [WIDTH-1:0]  opA,
  input  logic [WIDTH-1:0]  opB,
  input  logic              shCarry,
  input  logic              curC,
  input  logic              curV,
  output logic [WIDTH-1:0]  result,
  output logic              nNext,
  output logic              zNext,
  output logic              cNext,
  output logic              vNext
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] bEff;
  logic [WIDTH-1:0] sumVal;
  logic [WIDTH-1:0] logicVal;
  logic             carryIn;
  logic             carryOut;
  logic             overflow;

  assign bEff    = strobe.invertB ? ~opB : opB;
  assign carryIn = strobe.subtract | (strobe.addCarry & curC);

  assign {carryOut, sumVal} = {1'b0, opA} + {1'b0, bEff} + {{WIDTH{1'b0}}, carryIn};
  assign overflow = (opA[MSB] == bEff[MSB]) && (sumVal[MSB] != opA[MSB]);

  always_comb begin
    case (strobe.logicFn)
      LF_AND:  logicVal = opA & bEff;
      LF_OR:   logicVal = opA | bEff;
      LF_XOR:  logicVal = opA ^ bEff;
      default: logicVal = bEff;
    endcase
  end

  always_comb begin
    if (!strobe.valid)     result = '0;
    else if (strobe.arith) result = sumVal;
    else                   result = logicVal;
  end

  assign nNext = result[MSB];
  assign zNext = (result == '0);
  assign cNext = strobe.arith ? carryOut : shCarry;
  assign vNext = strobe.arith ? overflow : curV;

endmodule

// File: rtl/alu_flags.sv
module alu_flags
  import alu_flags_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       opCode,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             shCarry,
  input  logic             curC,
  input  logic             curV,
  input  logic             sBit,
  output logic [WIDTH-1:0] result,
  output logic             resWe,
  output logic             flagEn,
  output logic             nNext,
  output logic             zNext,
  output logic             cNext,
  output logic             vNext
);

  aluStrobe_t strobe;

  alu_flags_ctrl uCtrl (
    .opCode (opCode),
    .sBit   (sBit),
    .strobe (strobe),
    .resWe  (resWe),
    .flagEn (flagEn)
  );

  alu_flags_dpath #(.WIDTH(WIDTH)) uDpath (
    .strobe  (strobe),
    .opA     (opA),
    .opB     (opB),
    .shCarry (shCarry),
    .curC    (curC),
    .curV    (curV),
    .result  (result),
    .nNext   (nNext),
    .zNext   (zNext),
    .cNext   (cNext),
    .vNext   (vNext)
  );

endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk
  import alu_flags_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic [3:0]       opCode,
  input logic             sBit,
  input logic             shCarry,
  input logic             curV,
  input logic [WIDTH-1:0] result,
  input logic             resWe,
  input logic             flagEn,
  input logic             nNext,
  input logic             zNext,
  input logic             cNext,
  input logic             vNext
);

  logic isTest;
  logic isLogic;
  logic isResv;

  assign isTest  = (opCode == OP_TST) || (opCode == OP_TEQ) || (opCode == OP_CMP);
  assign isLogic = (opCode == OP_AND) || (opCode == OP_EOR) || (opCode == OP_ORR) ||
                   (opCode == OP_MOV) || (opCode == OP_BIC) || (opCode == OP_MVN);
  assign isResv  = (opCode > OP_MVN);

  always_comb begin
    if (!$isunknown({opCode, sBit, shCarry, curV, result, resWe, flagEn, nNext, zNext, cNext, vNext})) begin
      // R1
      p_no_write_test_r1: assert (!(isTest && resWe))
        else $error("test opcode wrote result");
      // R7
      p_test_flags_r7: assert (!isTest || flagEn)
        else $error("test opcode did not update flags");
      // R7
      p_flag_gate_r7: assert (isTest || sBit || !flagEn)
        else $error("flags updated without set-flags bit");
      // R4
      p_zero_flag_r4: assert (zNext == (result == '0))
        else $error("Z disagrees with result");
      // R4
      p_neg_flag_r4: assert (nNext == result[WIDTH-1])
        else $error("N disagrees with result");
      // R6
      p_logic_cv_r6: assert (!isLogic || (cNext == shCarry && vNext == curV))
        else $error("logical op altered C/V source");
      // R9
      p_reserved_r9: assert (!isResv || (!resWe && !flagEn && result == '0))
        else $error("reserved opcode had an effect");
    end
  end

endmodule

bind alu_flags alu_flags_chk #(.WIDTH(WIDTH)) uChk (
  .opCode  (opCode),
  .sBit    (sBit),
  .shCarry (shCarry),
  .curV    (curV),
  .result  (result),
  .resWe   (resWe),
  .flagEn  (flagEn),
  .nNext   (nNext),
  .zNext   (zNext),
  .cNext   (cNext),
  .vNext   (vNext)
);

// File: tb/sim_alu_flags.sv
`timescale 1ns/1ps
module sim_alu_flags;

  localparam int SW = 4;
  localparam int SM = (1 << SW) - 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  // small instance
  logic [3:0]    opCode = '0;
  logic [SW-1:0] opA = '0, opB = '0;
  logic shCarry = 0, curC = 0, curV = 0, sBit = 0;
  logic [SW-1:0] result;
  logic resWe, flagEn, nNext, zNext, cNext, vNext;

  alu_flags #(.WIDTH(SW)) u0 (
    .opCode(opCode), .opA(opA), .opB(opB), .shCarry(shCarry), .curC(curC),
    .curV(curV), .sBit(sBit), .result(result), .resWe(resWe), .flagEn(flagEn),
    .nNext(nNext), .zNext(zNext), .cNext(cNext), .vNext(vNext));

  // full-width instance
  logic [3:0]  wOp = '0;
  logic [31:0] wA = '0, wB = '0;
  logic wSh = 0, wC = 0, wV = 0, wS = 0;
  logic [31:0] wRes;
  logic wWe, wFe, wN, wZ, wCo, wVo;

  alu_flags #(.WIDTH(32)) u1 (
    .opCode(wOp), .opA(wA), .opB(wB), .shCarry(wSh), .curC(wC),
    .curV(wV), .sBit(wS), .result(wRes), .resWe(wWe), .flagEn(wFe),
    .nNext(wN), .zNext(wZ), .cNext(wCo), .vNext(wVo));

  task automatic check(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h (op=%0d a=%0d b=%0d)",
               tag, got, exp, opCode, opA, opB);
    end
  endtask

  function automatic int sgn(input int x);
    return (x > (SM >> 1)) ? x - (SM + 1) : x;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    // Quiescent all-zero state: AND of zeros, no flags requested
    @(negedge clk); #1;
    check("R1 idle write", resWe, 1);
    check("R7 idle flagEn", flagEn, 0);
    check("R4 idle Z", zNext, 1);

    for (int op = 0; op < 16; op++) begin
      for (int a = 0; a <= SM; a++) begin
        for (int b = 0; b <= SM; b++) begin
          for (int k = 0; k < 8; k++) begin
            int eRes, eC, eV, sr;
            bit eWe, eFe, arith, test, valid;
            @(negedge clk);
            opCode = 4'(op); opA = SW'(a); opB = SW'(b);
            curC = k[0]; shCarry = k[1]; sBit = k[2]; curV = k[0] ^ k[1];
            #1;
            arith = 0; test = (op >= 5 && op <= 7); valid = (op <= 11);
            eC = shCarry; eV = curV; eRes = 0;
            case (op)
              0, 5: eRes = a & b;
              1, 6: eRes = a ^ b;
              8:    eRes = a | b;
              9:    eRes = b;
              10:   eRes = a & ~b & SM;
              11:   eRes = ~b & SM;
              3, 4: begin
                arith = 1;
                eRes = a + b + ((op == 4) ? int'(curC) : 0);
                sr   = sgn(a) + sgn(b) + ((op == 4) ? int'(curC) : 0);
                eC   = eRes >> SW; eRes = eRes & SM;
                eV   = (sr > (SM >> 1) || sr < -((SM + 1) >> 1)) ? 1 : 0;
              end
              2, 7: begin
                arith = 1;
                eRes = (a - b) & SM;
                sr   = sgn(a) - sgn(b);
                eC   = (a >= b) ? 1 : 0;
                eV   = (sr > (SM >> 1) || sr < -((SM + 1) >> 1)) ? 1 : 0;
              end
              default: eRes = 0;
            endcase
            eWe = valid && !test;
            eFe = test || (eWe && sBit);
            if (!valid) begin
              check("R9 reserved result", result, 0);
              check("R9 reserved write", resWe, 0);
              check("R9 reserved flagEn", flagEn, 0);
            end else begin
              check(arith ? "R2 arith result" : "R3 logic result", result, eRes);
              check("R1 write enable", resWe, eWe);
              check("R7 flag enable", flagEn, eFe);
              check("R4 N flag", nNext, (eRes >> (SW - 1)) & 1);
              check("R4 Z flag", zNext, (eRes == 0) ? 1 : 0);
              check(arith ? "R5 arith C" : "R6 logic C", cNext, eC);
              check(arith ? "R6 arith V" : "R6 logic V", vNext, eV);
            end
          end
        end
      end
    end

    // Full-width directed cases
    @(negedge clk);
    wOp = 4'd10; wA = 32'h02FA62CA; wB = 32'h0000FFFF; #1;
    check("R3 BIC example", wRes, 32'h02FA0000);
    @(negedge clk);
    wOp = 4'd11; wB = 32'h4; #1;
    check("R3 MVN", wRes, 32'hFFFFFFFB);
    @(negedge clk);
    wOp = 4'd6; wA = 32'h5; wB = 32'h5; #1;
    check("R4 TEQ equal Z", wZ, 1);
    check("R7 TEQ flagEn", wFe, 1);
    // 64-bit: 0x00000001_FFFFFFFF + 0x00000002_00000001
    @(negedge clk);
    wOp = 4'd3; wS = 1; wA = 32'hFFFFFFFF; wB = 32'h00000001; wC = 0; #1;
    check("R8 low word", wRes, 32'h0);
    check("R8 low carry", wCo, 1);
    check("R8 low flagEn", wFe, 1);
    @(negedge clk);
    wC = wCo; wOp = 4'd4; wA = 32'h1; wB = 32'h2; #1;
    check("R8 high word", wRes, 32'h4);
    check("R8 high carry", wCo, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule